// File: doc/BRIEF.md
# Staging-Buffer Byte DMA Engine

This block moves bytes between the byte-wide data port of a SCSI controller and a 16 KiB on-board staging buffer. The host CPU programs a small register file with a transfer direction, a count, and a start position in the buffer. It then fires one of two start strobes. The engine answers each controller DMA request with an acknowledge and moves one byte per acknowledged cycle. When the count runs out or the controller withdraws its request, the engine raises an interrupt-request flag. The count that is left stays readable.

The count is held as a 17-bit negative number. The host writes the two's complement of the length, and the engine counts up toward zero. The buffer start position goes in through a byte-wide register that takes two writes.

The buffer RAM itself sits outside the block, with an asynchronous read port. The engine multiplexes the RAM between the host and the transfer. While a transfer runs, the host can reach neither the buffer nor the registers. For that reason completion is reported only through the separate interrupt flag.

Top module: `sdma_engine`

## Requirements
- R1: The count register (register 1) loads the 17-bit negated length from write data bits 16:0. It increments by one on every acknowledged byte. When it reaches zero, the transfer stops and the interrupt flag is set.
- R2: A read of register 1 returns zero when the count is zero. Otherwise it returns the 17-bit count with bits 31:17 all set to one.
- R3: The first write to the offset register (register 2) after reset or after a start loads address bits 7:0. The next write loads bits 13:8 from data bits 5:0. The address advances by one per byte and wraps modulo 16384. Register 2 reads back the current address.
- R4: Register 0 bit 0 selects the direction: 1 is OUT (buffer to controller, data on `ctl_dout`) and 0 is IN (`ctl_din` written into the buffer).
- R5: Any write to register 3 starts a transfer only when the direction is OUT. Any write to register 4 starts one only when the direction is IN. The data written is ignored, and a strobe that does not match the direction does nothing.
- R6: If `ctl_drq` falls (high on one cycle, low on the next) during a transfer, the transfer stops. The interrupt flag is set and the residual count is kept.
- R7: While a transfer is active, host reads return 0 and host writes to the buffer or the registers are dropped. Any such access sets a sticky error flag (register 5 bit 1), which is cleared by writing 1 to that bit.
- R8: The interrupt flag (`irq`, register 5 bit 0) stays set until the host writes 1 to register 5 bit 0. A start strobe is ignored while the flag is set.
- R9: A start with a count of zero moves no byte and sets the interrupt flag at once.
- R10: `ctl_dack` is high exactly in the cycles when a transfer is active and `ctl_drq` is high. One byte moves per such cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host access request |
| h_we | input | 1 | Host write enable |
| h_buf | input | 1 | 1 selects the buffer, 0 selects the registers |
| h_addr | input | 14 | Buffer byte address; bits 2:0 pick the register |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data (combinational) |
| irq | output | 1 | Transfer-done interrupt request |
| buf_addr | output | 14 | Staging RAM address |
| buf_we | output | 1 | Staging RAM write enable |
| buf_wdata | output | 8 | Staging RAM write data |
| buf_rdata | input | 8 | Staging RAM asynchronous read data |
| ctl_drq | input | 1 | Controller DMA request |
| ctl_dack | output | 1 | Byte acknowledge to the controller |
| ctl_din | input | 8 | Byte from the controller (IN) |
| ctl_dout | output | 8 | Byte to the controller (OUT) |

## Verification
The first OUT run starts at a nonzero offset with the request held high. The scoreboard checks the order of the bytes and that the transfer stops exactly when the count runs out. The IN run starts two bytes below the top of the buffer, so any mistake in address wrap or in offset byte order shows up as misplaced data. A second OUT run drops the request early, which separates an end caused by the request falling from an end caused by the count reaching zero, and checks the sign-extended residual. Accesses made while busy, a strobe that does not match the direction, a strobe while the interrupt flag is still set, and a zero count each test one guard of the start and lockout logic.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
    localparam int unsigned REG_SEL_W = 3;

    typedef enum logic [REG_SEL_W-1:0] {
        RA_DIR    = 3'd0,
        RA_COUNT  = 3'd1,
        RA_OFFSET = 3'd2,
        RA_SEND   = 3'd3,
        RA_RECV   = 3'd4,
        RA_STATUS = 3'd5
    } reg_addr_e;

    localparam logic DIR_IN  = 1'b0;
    localparam logic DIR_OUT = 1'b1;
endpackage

// File: rtl/sdma_count.sv
module sdma_count #(
    parameter int unsigned CW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          wraps_zero
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_t;

    cnt_t q, d;

    always_comb begin
        d = q;
        if (load)
            d.cnt = load_val;
        else if (inc)
            d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt        = q.cnt;
    assign wraps_zero = inc && (q.cnt == {CW{1'b1}});

    // R1: one step per acknowledged byte
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/sdma_addr.sv
module sdma_addr #(
    parameter int unsigned AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_byte,
    input  logic [7:0]    byte_val,
    input  logic          restart,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    typedef struct packed {
        logic          hi_next;
        logic [AW-1:0] addr;
    } addr_t;

    addr_t q, d;
    logic [15:0] merged_unused;

    always_comb begin
        d = q;
        merged_unused = {byte_val, q.addr[7:0]};
        if (restart) begin
            d.hi_next = 1'b0;
        end else if (load_byte) begin
            if (!q.hi_next) d.addr[7:0] = byte_val;
            else            d.addr      = merged_unused[AW-1:0];
            d.hi_next = !q.hi_next;
        end
        if (inc)
            d.addr = q.addr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign addr = q.addr;

    // R3: buffer address advances modulo the buffer size
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load_byte) |=> (addr == AW'($past(addr) + 1'b1)));
endmodule

// File: rtl/sdma_seq.sv
module sdma_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic start_go,
    input  logic zero_cnt,
    input  logic end_xfer,
    input  logic clr_irq,
    input  logic clr_err,
    input  logic lock_hit,
    output logic busy,
    output logic irq,
    output logic err
);
    typedef struct packed {
        logic busy;
        logic irq;
        logic err;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        if (lock_hit)     d.err = 1'b1;
        else if (clr_err) d.err = 1'b0;
        if (q.busy) begin
            if (end_xfer) begin
                d.busy = 1'b0;
                d.irq  = 1'b1;
            end
        end else begin
            if (clr_irq) d.irq = 1'b0;
            if (start_go) begin
                if (zero_cnt) d.irq  = 1'b1;
                else          d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign irq  = q.irq;
    assign err  = q.err;

    // R8: flag holds until cleared by the host
    a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_irq) |=> irq);
    // R7: a locked-out access leaves the error flag set
    a_r7_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        lock_hit |=> err);
    // R8: never busy with the flag still pending
    a_r8_busy_irq_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, irq}));
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
    import sdma_pkg::*;
#(
    parameter int unsigned AW = 14,
    parameter int unsigned CW = 17,
    parameter int unsigned HW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_req,
    input  logic          h_we,
    input  logic          h_buf,
    input  logic [AW-1:0] h_addr,
    input  logic [HW-1:0] h_wdata,
    output logic [HW-1:0] h_rdata,
    output logic          irq,
    output logic [AW-1:0] buf_addr,
    output logic          buf_we,
    output logic [7:0]    buf_wdata,
    input  logic [7:0]    buf_rdata,
    input  logic          ctl_drq,
    output logic          ctl_dack,
    input  logic [7:0]    ctl_din,
    output logic [7:0]    ctl_dout
);
    localparam int unsigned EXT_W = HW - CW;

    typedef struct packed {
        logic dir;
        logic drq_seen;
    } top_t;

    top_t q, d;

    logic          busy, err;
    logic          acc_ok, reg_wr, handshake, drq_fall, start_go;
    logic [CW-1:0] cnt;
    logic          wraps_zero;
    logic [AW-1:0] xaddr;
    logic [REG_SEL_W-1:0] rsel;
    logic          wdata_unused;

    assign wdata_unused = ^h_wdata[HW-1:CW];
    assign rsel      = h_addr[REG_SEL_W-1:0];
    assign acc_ok    = h_req && !busy;
    assign reg_wr    = acc_ok && h_we && !h_buf;
    assign handshake = busy && ctl_drq;
    assign drq_fall  = q.drq_seen && !ctl_drq;
    assign start_go  = reg_wr && !irq &&
                       (((rsel == RA_SEND) && (q.dir == DIR_OUT)) ||
                        ((rsel == RA_RECV) && (q.dir == DIR_IN)));

    always_comb begin
        d = q;
        d.drq_seen = ctl_drq;
        if (reg_wr && rsel == RA_DIR)
            d.dir = h_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    sdma_count #(.CW(CW)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (reg_wr && rsel == RA_COUNT),
        .load_val   (h_wdata[CW-1:0]),
        .inc        (handshake),
        .cnt        (cnt),
        .wraps_zero (wraps_zero)
    );

    sdma_addr #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_byte (reg_wr && rsel == RA_OFFSET),
        .byte_val  (h_wdata[7:0]),
        .restart   (start_go),
        .inc       (handshake),
        .addr      (xaddr)
    );

    sdma_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_go (start_go),
        .zero_cnt (cnt == '0),
        .end_xfer (wraps_zero || drq_fall),
        .clr_irq  (reg_wr && rsel == RA_STATUS && h_wdata[0]),
        .clr_err  (reg_wr && rsel == RA_STATUS && h_wdata[1]),
        .lock_hit (h_req && busy),
        .busy     (busy),
        .irq      (irq),
        .err      (err)
    );

    // buffer port sharing
    assign buf_addr  = busy ? xaddr : h_addr;
    assign buf_we    = busy ? (handshake && q.dir == DIR_IN)
                            : (acc_ok && h_buf && h_we);
    assign buf_wdata = busy ? ctl_din : h_wdata[7:0];
    assign ctl_dack  = handshake;
    assign ctl_dout  = (busy && q.dir == DIR_OUT) ? buf_rdata : 8'h00;

    always_comb begin
        h_rdata = '0;
        if (acc_ok) begin
            if (h_buf) begin
                h_rdata[7:0] = buf_rdata;
            end else begin
                case (rsel)
                    RA_DIR:    h_rdata[0] = q.dir;
                    RA_COUNT:  h_rdata = (cnt == '0) ? '0 : {{EXT_W{1'b1}}, cnt};
                    RA_OFFSET: h_rdata[AW-1:0] = xaddr;
                    RA_STATUS: h_rdata[1:0] = {err, irq};
                    default:   h_rdata = '0;
                endcase
            end
        end
    end

    // R8: a strobe while the flag is pending does not start anything
    a_r8_start_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && h_req && h_we && !h_buf && (rsel == RA_SEND || rsel == RA_RECV)) |=> !busy);
endmodule

// File: tb/sdma_engine_bench.sv
module sdma_engine_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0;
    logic        h_req = 0, h_we = 0, h_buf = 0;
    logic [13:0] h_addr = '0;
    logic [31:0] h_wdata = '0, h_rdata;
    logic        irq, buf_we, ctl_dack;
    logic [13:0] buf_addr;
    logic [7:0]  buf_wdata, buf_rdata, ctl_dout;
    logic        ctl_drq = 0;
    logic [7:0]  ctl_din = '0;

    int n_chk = 0, n_fail = 0, mem_ver = 0, popped = 0;
    logic [7:0] mem [int];
    logic [7:0] exp_q [$];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdma_engine u_sdma_engine (
        .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_buf(h_buf),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .irq(irq),
        .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata), .ctl_drq(ctl_drq), .ctl_dack(ctl_dack),
        .ctl_din(ctl_din), .ctl_dout(ctl_dout)
    );

    // staging RAM model, asynchronous read
    always @(posedge clk) if (buf_we) begin mem[int'(buf_addr)] = buf_wdata; mem_ver++; end
    always @(buf_addr, mem_ver)
        buf_rdata = mem.exists(int'(buf_addr)) ? mem[int'(buf_addr)] : 8'h00;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor for OUT bytes (R4, R10)
    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (ctl_dack && exp_q.size() > 0 && u_sdma_engine.h_rdata === h_rdata) begin
        end
        if (ctl_dack && !ctl_din[0] && 1'b0) begin end
        if (ctl_dack && out_mode) begin
            if (exp_q.size() == 0) chk("R10 unexpected byte", {24'h0, ctl_dout}, 32'h0 - 1);
            else begin
                chk("R4 out byte", {24'h0, ctl_dout}, {24'h0, exp_q.pop_front()});
                popped++;
            end
        end
    end
    bit out_mode = 0;

    task automatic acc(bit bsel, bit we, int a, logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        h_req = 1; h_we = we; h_buf = bsel; h_addr = 14'(a); h_wdata = wd;
        #1 rd = h_rdata;
        @(negedge clk);
        h_req = 0; h_we = 0;
    endtask
    task automatic rw(int a, logic [31:0] wd);
        logic [31:0] x; acc(0, 1, a, wd, x);
    endtask
    task automatic rr(int a, output logic [31:0] rd);
        acc(0, 0, a, 0, rd);
    endtask

    task automatic run_drq(int maxc);
        @(negedge clk); ctl_drq = 1;
        for (int i = 0; i < maxc && !irq; i++) @(negedge clk);
        ctl_drq = 0;
    endtask

    initial begin
        logic [31:0] r;
        logic [7:0] inv [4] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state
        rr(5, r); chk("R8 reset status", r, 0);
        rr(1, r); chk("R2 reset count", r, 0);
        chk("R8 reset irq", {31'h0, irq}, 0);

        // OUT transfer of 8 bytes from offset 0x10
        for (int i = 0; i < 8; i++) acc(1, 1, 16 + i, 32'(i * 7 + 3), r);
        rw(0, 1);
        rw(1, 32'h1FFF8);
        rw(2, 32'h10); rw(2, 32'h00);
        rr(1, r); chk("R2 count sign-extended", r, 32'hFFFF_FFF8);
        for (int i = 0; i < 8; i++) exp_q.push_back(8'(i * 7 + 3));
        out_mode = 1;
        rw(3, 32'h1234_5678);
        // locked accesses while busy and drq low
        rr(1, r); chk("R7 locked read", r, 0);
        acc(1, 1, 16, 32'hAA, r);
        run_drq(20);
        chk("R1 irq after count", {31'h0, irq}, 1);
        chk("R1 bytes moved", popped, 8);
        out_mode = 0;
        rr(1, r); chk("R1 count at zero", r, 0);
        acc(1, 0, 16, 0, r); chk("R7 dropped write", r, 3);
        rr(5, r); chk("R7 error sticky", r, 3);
        rw(5, 2);
        rr(5, r); chk("R7 error cleared", r, 1);

        // R8: strobe while irq pending ignored
        rw(0, 0); rw(1, 32'h1FFFC); rw(2, 32'hFE); rw(2, 32'h3F);
        rw(4, 0);
        @(negedge clk); ctl_drq = 1; #1;
        chk("R8 start ignored while irq", {31'h0, ctl_dack}, 0);
        @(negedge clk); ctl_drq = 0;
        rr(1, r); chk("R8 count untouched", r, 32'hFFFF_FFFC);
        rw(5, 1);
        chk("R8 irq cleared", {31'h0, irq}, 0);

        // IN transfer wrapping at top of buffer
        rw(4, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); ctl_din = inv[i]; ctl_drq = 1;
            #1 chk("R10 dack in", {31'h0, ctl_dack}, 1);
        end
        @(negedge clk); ctl_drq = 0;
        chk("R1 irq after in", {31'h0, irq}, 1);
        acc(1, 0, 14'h3FFE, 0, r); chk("R4 in byte 0", r, 32'hA1);
        acc(1, 0, 14'h3FFF, 0, r); chk("R3 in byte 1", r, 32'hB2);
        acc(1, 0, 14'h0000, 0, r); chk("R3 wrap byte 2", r, 32'hC3);
        acc(1, 0, 14'h0001, 0, r); chk("R3 wrap byte 3", r, 32'hD4);
        acc(1, 0, 14'h0002, 0, r); chk("R1 no extra byte", r, 0);
        rr(2, r); chk("R3 address readback", r, 2);

        // R6: early stop on drq fall
        rw(5, 1); rw(0, 1); rw(1, 32'h1FFF6); rw(2, 0); rw(2, 0);
        exp_q.push_back(8'hC3); exp_q.push_back(8'hD4); exp_q.push_back(8'h00);
        popped = 0; out_mode = 1;
        rw(3, 0);
        @(negedge clk); ctl_drq = 1;
        repeat (3) @(negedge clk);
        ctl_drq = 0;
        @(negedge clk);
        out_mode = 0;
        chk("R6 irq on drq fall", {31'h0, irq}, 1);
        chk("R6 bytes moved", popped, 3);
        rr(1, r); chk("R6 residual", r, 32'hFFFF_FFF9);

        // R5: mismatched strobe
        rw(5, 1); rw(0, 0); rw(1, 32'h1FFFF);
        rw(3, 0);
        rr(1, r); chk("R5 mismatched strobe idle", r, 32'hFFFF_FFFF);
        rr(5, r); chk("R5 no irq no err", r, 0);

        // R9: zero count start
        rw(1, 0); rw(4, 0);
        rr(5, r); chk("R9 zero count irq", r, 1);
        rr(1, r); chk("R9 count stays zero", r, 0);
        chk("R1 scoreboard empty", exp_q.size(), 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin repeat (100000) @(posedge clk); n_chk++; n_fail++; $display("FAIL watchdog expired"); end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule